// File: doc/BRIEF.md
# Network Controller Configuration and Event Register Bank

This block is a byte-wide set of control and status registers for a small Ethernet switch or controller. A processor reaches it through a plain bus that has an address, a write strobe, a read strobe and 8-bit data in each direction. The block holds four registers: network control, network status, transmit control and receive control. Their bits drive the datapath's mode pins, such as loopback, receive enable and promiscuous mode. The bank also issues the transmit request and a timed soft reset.

The datapath sends single-cycle event pulses into the bank: a link change, a transmit completion for packet slot 1, a transmit completion for slot 2, and a wakeup event. Each pulse latches into a sticky status bit. Software selects at run time how the transmit-complete bits are cleared. Either a read of the status register clears them, or only a write of 1 to a bit clears that bit. The link-change bit always clears on a write of 1. The wake enable survives a soft reset, and clearing it also drops the latched wakeup flag.

Top module: `ethRegBank`

## Requirements
- R1: After the reset input is released, every register reads 0x00 and every control output is 0.
- R2: Network control sits at address 0x00 with this layout: bit 6 is wake enable, bit 5 is the clear-mode select, bit 1 is loopback and bit 0 is soft reset. Bits 7 and 4:2 read as 0, and writes to them are ignored.
- R3: Transmit control sits at address 0x02 with this layout: bit 3 turns off CRC append for slot 2, bit 1 turns it off for slot 1, and bit 0 is the transmit request. All other bits read as 0.
- R4: Receive control sits at address 0x05 with this layout: bit 7 passes every hash address, bit 4 drops frames with CRC errors, bit 3 passes all multicast frames, bit 1 selects promiscuous mode and bit 0 enables receive. Bits 6, 5 and 2 read as 0.
- R5: The transmit request clears when either slot's transmit-complete pulse arrives. A write to transmit control in the same cycle takes priority over that clear.
- R6: Network status sits at address 0x01. Bit 5 is link change, bit 3 is slot-2 complete and bit 2 is slot-1 complete. Each bit is set by its event pulse, and all other bits read as 0.
- R7: With clear-mode 0, read data appears on busRdata in the cycle after the read strobe and holds the value from before any clear. A read of status clears bits 3 and 2.
- R8: With clear-mode 1, a read does not clear status, and writing 1 clears bits 3 and 2. Bit 5 clears only on a write of 1, whatever the clear-mode setting.
- R9: If an event pulse and a clear (by read or by a write of 1) reach the same status bit in the same cycle, the bit ends up set.
- R10: Writing 1 to control bit 0 starts a timer of CLK_MHZ*RST_US cycles. While the timer runs, the bit reads 1 and softRst is high. Every register is held at 0 during that time, except the wake enable and the wakeup flag.
- R11: A wakeup event sets wakeFlag only while wake enable is 1. Writing wake enable to 0 clears wakeFlag.
- R12: A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read strobe, one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after busRd |
| linkChgPulse | input | 1 | Link state changed on a port |
| txDone1Pulse | input | 1 | Slot 1 transmission finished |
| txDone2Pulse | input | 1 | Slot 2 transmission finished |
| wakeEvent | input | 1 | Wakeup event seen |
| txReq | output | 1 | Transmit request |
| crcOff1 | output | 1 | Turn off CRC append, slot 1 |
| crcOff2 | output | 1 | Turn off CRC append, slot 2 |
| loopback | output | 1 | Loopback test mode |
| softRst | output | 1 | Soft reset in progress |
| rxEnable | output | 1 | Receive enable |
| promisc | output | 1 | Promiscuous mode |
| passAllMcast | output | 1 | Pass all multicast frames |
| dropCrcErr | output | 1 | Drop frames with CRC errors |
| hashPassAll | output | 1 | Pass every hash address |
| wakeEnable | output | 1 | Wake enable |
| wakeFlag | output | 1 | Latched wakeup status |

## Verification
Most wrong internal states in this block show up at the ports within a single cycle. A status bit that is lost or cleared when it should not be appears as a wrong value on the next status read, which lands one cycle after the strobe. A wrong clear-mode flag shows as a second read that fails to match the first. A soft-reset timer of the wrong length shows only at its expiry, about 2000 cycles after it starts. By then softRst and the control bit 0 readback should both have fallen, and registers should have reset while wakeEnable and wakeFlag keep their values.

// File: rtl/ethRegBank_pkg.sv
package ethRegBank_pkg;
  localparam int DATA_W = 8;
  localparam int ADR_NETCTL = 'h00;
  localparam int ADR_NETSTS = 'h01;
  localparam int ADR_TXCTL  = 'h02;
  localparam int ADR_RXCTL  = 'h05;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_NETCTL, SEL_NETSTS, SEL_TXCTL, SEL_RXCTL
  } rdSel_t;

  typedef struct packed {
    logic   wrNetCtl;
    logic   wrNetSts;
    logic   wrTxCtl;
    logic   wrRxCtl;
    logic   rdNetSts;
    logic   rdAny;
    rdSel_t rdSel;
    logic   softActive;
  } regStrobe_t;
endpackage

// File: rtl/ethRegBank_ctrl.sv
module ethRegBank_ctrl
  import ethRegBank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_MHZ = 200,
  parameter int RST_US  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              startBit,
  output regStrobe_t        strb
);
  localparam int CNT_MAX = CLK_MHZ * RST_US;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] rstCnt;
  logic hitNetCtl, hitNetSts, hitTxCtl, hitRxCtl;

  always_comb begin
    hitNetCtl = (busAddr == ADDR_W'(ADR_NETCTL));
    hitNetSts = (busAddr == ADDR_W'(ADR_NETSTS));
    hitTxCtl  = (busAddr == ADDR_W'(ADR_TXCTL));
    hitRxCtl  = (busAddr == ADDR_W'(ADR_RXCTL));
    strb.wrNetCtl   = busWr && hitNetCtl;
    strb.wrNetSts   = busWr && hitNetSts;
    strb.wrTxCtl    = busWr && hitTxCtl;
    strb.wrRxCtl    = busWr && hitRxCtl;
    strb.rdNetSts   = busRd && hitNetSts;
    strb.rdAny      = busRd;
    strb.softActive = (rstCnt != '0);
    if (hitNetCtl)      strb.rdSel = SEL_NETCTL;
    else if (hitNetSts) strb.rdSel = SEL_NETSTS;
    else if (hitTxCtl)  strb.rdSel = SEL_TXCTL;
    else if (hitRxCtl)  strb.rdSel = SEL_RXCTL;
    else                strb.rdSel = SEL_NONE;
  end

  // soft reset timer: a load while it is already running is ignored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rstCnt <= '0;
    else if (busWr && hitNetCtl && startBit && rstCnt == '0)
      rstCnt <= CNT_W'(CNT_MAX);
    else if (rstCnt != '0)
      rstCnt <= rstCnt - 1'b1;
  end
endmodule

// File: rtl/ethRegBank_dp.sv
module ethRegBank_dp
  import ethRegBank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              linkChgPulse,
  input  logic              txDone1Pulse,
  input  logic              txDone2Pulse,
  input  logic              wakeEvent,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] nsrBits,
  output logic              txReq,
  output logic              crcOff1,
  output logic              crcOff2,
  output logic              loopback,
  output logic              rxEnable,
  output logic              promisc,
  output logic              passAllMcast,
  output logic              dropCrcErr,
  output logic              hashPassAll,
  output logic              wakeEnable,
  output logic              wakeFlag
);
  logic clrMode, linkChg, tx1Done, tx2Done;
  logic rdClr;
  logic [DATA_W-1:0] w1c, rdMux;

  assign rdClr = strb.rdNetSts && !clrMode;
  assign w1c   = strb.wrNetSts ? busWdata : '0;
  assign nsrBits = {2'b00, linkChg, 1'b0, tx2Done, tx1Done, 2'b00};

  // wake enable and flag: outside the soft-reset domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEnable <= 1'b0;
      wakeFlag   <= 1'b0;
    end else begin
      if (strb.wrNetCtl) wakeEnable <= busWdata[6];
      if (strb.wrNetCtl && !busWdata[6]) wakeFlag <= 1'b0;
      else if (wakeEvent && wakeEnable)  wakeFlag <= 1'b1;
    end
  end

  // soft-resettable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || strb.softActive) begin
      {clrMode, loopback} <= '0;
      {linkChg, tx1Done, tx2Done} <= '0;
      {txReq, crcOff1, crcOff2} <= '0;
      {rxEnable, promisc, passAllMcast, dropCrcErr, hashPassAll} <= '0;
    end else begin
      if (strb.wrNetCtl) begin
        clrMode  <= busWdata[5];
        loopback <= busWdata[1];
      end
      // set beats any clear
      if (linkChgPulse)  linkChg <= 1'b1;
      else if (w1c[5])   linkChg <= 1'b0;
      if (txDone1Pulse)          tx1Done <= 1'b1;
      else if (rdClr || w1c[2])  tx1Done <= 1'b0;
      if (txDone2Pulse)          tx2Done <= 1'b1;
      else if (rdClr || w1c[3])  tx2Done <= 1'b0;
      if (strb.wrTxCtl) begin
        txReq   <= busWdata[0];
        crcOff1 <= busWdata[1];
        crcOff2 <= busWdata[3];
      end else if (txDone1Pulse || txDone2Pulse) begin
        txReq <= 1'b0;
      end
      if (strb.wrRxCtl) begin
        hashPassAll  <= busWdata[7];
        dropCrcErr   <= busWdata[4];
        passAllMcast <= busWdata[3];
        promisc      <= busWdata[1];
        rxEnable     <= busWdata[0];
      end
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_NETCTL: rdMux = {1'b0, wakeEnable, clrMode, 3'b000, loopback, strb.softActive};
      SEL_NETSTS: rdMux = nsrBits;
      SEL_TXCTL:  rdMux = {4'b0000, crcOff2, 1'b0, crcOff1, txReq};
      SEL_RXCTL:  rdMux = {hashPassAll, 2'b00, dropCrcErr, passAllMcast, 1'b0, promisc, rxEnable};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdAny) busRdata <= rdMux;
  end
endmodule

// File: rtl/ethRegBank.sv
module ethRegBank
  import ethRegBank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_MHZ = 200,
  parameter int RST_US  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              linkChgPulse,
  input  logic              txDone1Pulse,
  input  logic              txDone2Pulse,
  input  logic              wakeEvent,
  output logic              txReq,
  output logic              crcOff1,
  output logic              crcOff2,
  output logic              loopback,
  output logic              softRst,
  output logic              rxEnable,
  output logic              promisc,
  output logic              passAllMcast,
  output logic              dropCrcErr,
  output logic              hashPassAll,
  output logic              wakeEnable,
  output logic              wakeFlag
);
  regStrobe_t strb;
  logic [DATA_W-1:0] nsrBits;

  assign softRst = strb.softActive;

  ethRegBank_ctrl #(.ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .RST_US(RST_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .startBit(busWdata[0]), .strb(strb)
  );

  ethRegBank_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .linkChgPulse(linkChgPulse), .txDone1Pulse(txDone1Pulse),
    .txDone2Pulse(txDone2Pulse), .wakeEvent(wakeEvent),
    .busRdata(busRdata), .nsrBits(nsrBits), .txReq(txReq),
    .crcOff1(crcOff1), .crcOff2(crcOff2), .loopback(loopback),
    .rxEnable(rxEnable), .promisc(promisc), .passAllMcast(passAllMcast),
    .dropCrcErr(dropCrcErr), .hashPassAll(hashPassAll),
    .wakeEnable(wakeEnable), .wakeFlag(wakeFlag)
  );
endmodule

// File: rtl/ethRegBank_chk.sv
module ethRegBank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              linkChgPulse,
  input logic              txDone1Pulse,
  input logic              txDone2Pulse,
  input logic              wakeEvent,
  input logic              txReq,
  input logic              softRst,
  input logic              wakeEnable,
  input logic              wakeFlag,
  input logic [7:0]        nsrBits
);
  logic mapped;
  assign mapped = (busAddr == ADDR_W'(0)) || (busAddr == ADDR_W'(1)) ||
                  (busAddr == ADDR_W'(2)) || (busAddr == ADDR_W'(5));

  assert_txreq_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReq) |-> $past(txDone1Pulse || txDone2Pulse || softRst ||
                           (busWr && busAddr == ADDR_W'(2))));

  assert_tx1_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txDone1Pulse && !softRst) |=> nsrBits[2]);

  assert_link_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (linkChgPulse && !softRst) |=> nsrBits[5]);

  assert_soft_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRst) |-> $past(busWr && busAddr == ADDR_W'(0) && busWdata[0]));

  assert_wake_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !(busWr && busAddr == ADDR_W'(0))) |=> $stable(wakeEnable));

  assert_wake_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeEnable) |-> !wakeFlag);

  assert_wake_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(wakeEvent && wakeEnable));

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !mapped) |=> busRdata == 8'h00);
endmodule

bind ethRegBank ethRegBank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ethRegBank.sv
`timescale 1ns/1ps
module sim_ethRegBank;
  localparam int RST_CYC = 200 * 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic linkChgPulse = 1'b0, txDone1Pulse = 1'b0, txDone2Pulse = 1'b0, wakeEvent = 1'b0;
  logic [7:0] busRdata;
  logic txReq, crcOff1, crcOff2, loopback, softRst, rxEnable, promisc;
  logic passAllMcast, dropCrcErr, hashPassAll, wakeEnable, wakeFlag;

  int errors = 0;
  int checks = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  ethRegBank u0 (.*);

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // driver: queue the expected value, then strobe the read
  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: linkChgPulse = 1'b1;
      1: txDone1Pulse = 1'b1;
      2: txDone2Pulse = 1'b1;
      default: wakeEvent = 1'b1;
    endcase
    @(negedge clk);
    {linkChgPulse, txDone1Pulse, txDone2Pulse, wakeEvent} = '0;
  endtask

  // monitor: read data is due one edge after the strobe
  initial begin
    forever begin
      logic hit;
      @(posedge clk);
      hit = busRd;
      @(negedge clk);
      if (hit) begin
        if (expQ.size() == 0) check(busRdata, 8'hxx, "scoreboard underflow");
        else check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'h00, 8'h00, "R1 netctl reset");
    rd(8'h01, 8'h00, "R1 netsts reset");
    rd(8'h02, 8'h00, "R1 txctl reset");
    rd(8'h05, 8'h00, "R1 rxctl reset");
    check({txReq, loopback, softRst, rxEnable, wakeEnable, wakeFlag}, 8'h00, "R1 outputs reset");

    // R2 network control layout, reserved bits ignored
    wr(8'h00, 8'h62);
    rd(8'h00, 8'h62, "R2 netctl readback");
    wr(8'h00, 8'hFE);
    rd(8'h00, 8'h62, "R2 reserved bits ignored");
    check({7'b0, loopback}, 8'h01, "R2 loopback pin");

    // R4 receive control
    wr(8'h05, 8'hFF);
    rd(8'h05, 8'h9B, "R4 rxctl readback");
    check({3'b0, hashPassAll, dropCrcErr, passAllMcast, promisc, rxEnable}, 8'h1F, "R4 rx pins");

    // R3 transmit control, R5 request clear, R8 clear-mode 1
    wr(8'h02, 8'hFF);
    rd(8'h02, 8'h0B, "R3 txctl readback");
    check({5'b0, crcOff2, crcOff1, txReq}, 8'h07, "R3 tx pins");
    pulse(1);
    check({7'b0, txReq}, 8'h00, "R5 request cleared by slot1 done");
    rd(8'h02, 8'h0A, "R5 txctl after done");
    rd(8'h01, 8'h04, "R6 slot1 status set");
    rd(8'h01, 8'h04, "R8 read does not clear");
    wr(8'h01, 8'h04);
    rd(8'h01, 8'h00, "R8 write one clears");

    // R7 clear-on-read, R8 link always write-one
    wr(8'h00, 8'h40);
    pulse(2);
    rd(8'h01, 8'h08, "R7 slot2 status read");
    rd(8'h01, 8'h00, "R7 cleared by read");
    pulse(0);
    rd(8'h01, 8'h20, "R6 link status set");
    rd(8'h01, 8'h20, "R8 link not cleared by read");
    wr(8'h01, 8'h20);
    rd(8'h01, 8'h00, "R8 link write one clears");

    // R9 set wins over read clear and write clear
    @(negedge clk);
    expQ.push_back(8'h00); tagQ.push_back("R9 read captures pre-event");
    busAddr = 8'h01; busRd = 1'b1; txDone1Pulse = 1'b1;
    @(negedge clk);
    busRd = 1'b0; txDone1Pulse = 1'b0;
    rd(8'h01, 8'h04, "R9 event beats read clear");
    rd(8'h01, 8'h00, "R9 then read clears");
    @(negedge clk);
    busAddr = 8'h01; busWdata = 8'h20; busWr = 1'b1; linkChgPulse = 1'b1;
    @(negedge clk);
    busWr = 1'b0; linkChgPulse = 1'b0;
    rd(8'h01, 8'h20, "R9 event beats write clear");
    wr(8'h01, 8'h20);

    // R5 write wins over completion in the same cycle
    @(negedge clk);
    busAddr = 8'h02; busWdata = 8'h01; busWr = 1'b1; txDone2Pulse = 1'b1;
    @(negedge clk);
    busWr = 1'b0; txDone2Pulse = 1'b0;
    check({7'b0, txReq}, 8'h01, "R5 write beats done");
    rd(8'h01, 8'h08, "R6 slot2 from same cycle");

    // R11 wake flag, R10 soft reset
    pulse(3);
    check({7'b0, wakeFlag}, 8'h01, "R11 wake flag set");
    wr(8'h05, 8'h01);
    wr(8'h00, 8'h43);
    check({7'b0, softRst}, 8'h01, "R10 soft reset asserted");
    rd(8'h00, 8'h41, "R10 bit0 reads one while running");
    repeat (RST_CYC + 4) @(negedge clk);
    check({7'b0, softRst}, 8'h00, "R10 soft reset ended");
    rd(8'h00, 8'h40, "R10 wake enable survives");
    rd(8'h05, 8'h00, "R10 rxctl cleared");
    rd(8'h02, 8'h00, "R10 txctl cleared");
    check({6'b0, loopback, wakeFlag}, 8'h01, "R10 loopback cleared, flag kept");

    // R11 disable clears and gates flag
    wr(8'h00, 8'h00);
    check({6'b0, wakeEnable, wakeFlag}, 8'h00, "R11 disable clears flag");
    pulse(3);
    check({7'b0, wakeFlag}, 8'h00, "R11 event ignored when disabled");

    // R12 unmapped
    rd(8'h03, 8'h00, "R12 unmapped 0x03");
    rd(8'h10, 8'h00, "R12 unmapped 0x10");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule